// File: doc/BRIEF.md
# SPI Slave Port with Stall Backpressure

This block is the serial host port of a link receiver. An external SPI master addresses one of three channels through three active-low selects: two byte-stream data channels and one configuration channel. Each data channel writes into its own small receive FIFO, which the receiver core drains one byte at a time. Configuration bytes go out as a one-cycle strobe with the byte next to it, for a register decoder that is not part of this block.

SCK, the selects and MOSI are brought into the core clock through two-flop synchronizers, and clock edges are found there. The core clock must run at least four times faster than SCK. Clock polarity and phase are static inputs, so any of the four SPI modes can be used. While a data channel is selected and its FIFO is close to full, a stall output tells the master to stop sending. A single-channel mode uses only select 0 and lets a read/write input choose the direction of the transfer.

Top module: `spi_stall_slave`

## Requirements
- R1: After reset, stall, mbox, ovf, miso_oe and cfg_valid are all low.
- R2: In every mode (cpol, cpha), bits on MOSI are taken most significant first, and each completed byte enters the FIFO of the selected data channel unchanged.
- R3: In every mode, MISO carries tx_byte most significant first. tx_byte is loaded when the select goes active and again at each byte boundary.
- R4: cs_n[0] addresses data FIFO 0, cs_n[1] data FIFO 1 and cs_n[2] the configuration channel. A configuration byte produces a one-cycle cfg_valid with cfg_byte and writes to neither FIFO. When several selects are low, the lowest index wins.
- R5: stall is high while a data channel is selected and its FIFO has one or no free entries (7 or 8 of 8 used). It is low when no select is active or when the configuration channel is selected.
- R6: mbox[i] is high exactly while FIFO i holds at least one byte.
- R7: A byte that arrives for a full FIFO is dropped, the FIFO contents stay unchanged, and ovf[i] goes high and stays high until reset.
- R8: Bits of an incomplete byte are discarded when the select goes inactive. The next transfer starts a fresh byte.
- R9: miso_oe is low while no channel is selected, and also in single-channel mode while rw_sel is low. It is high during any other selected transfer.
- R10: With single_mode high, cs_n[1] and cs_n[2] are ignored. rw_sel high (read) stores no MOSI byte, and rw_sel low (write) stores it. With single_mode low, rw_sel has no effect.
- R11: Each FIFO returns bytes in arrival order on rd_byte0/rd_byte1 (the head byte is shown before it is popped). A pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at least 4x SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI serial clock from the master |
| cs_n | input | 3 | Active-low selects: 0 data0, 1 data1, 2 config |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge |
| single_mode | input | 1 | Single-channel mode: only cs_n[0] is used |
| rw_sel | input | 1 | In single-channel mode, 1 = read, 0 = write |
| tx_byte | input | 8 | Byte to shift out on MISO |
| stall | output | 1 | Backpressure to the master |
| mbox | output | 2 | Per-channel data-pending flags |
| ovf | output | 2 | Sticky per-channel overflow flags |
| rd_pop | input | 2 | Per-channel FIFO pop |
| rd_byte0 | output | 8 | Head byte of FIFO 0 |
| rd_byte1 | output | 8 | Head byte of FIFO 1 |
| cfg_valid | output | 1 | Configuration byte strobe |
| cfg_byte | output | 8 | Configuration byte |

## Verification
On every cycle, the assertions check the following: a full FIFO keeps its count when a write is refused, a pop on an empty FIFO leaves it empty, the overflow flags never clear, stall only appears while a data channel is selected, and a configuration strobe never coincides with a FIFO write. Other behaviours depend on a sequence of SCK edges, so only the bench scenarios can show them. These are bit order in each of the four modes, the byte shifted back on MISO, the discarding of a partial byte, the exact fill level at which stall rises, and which selects single-channel mode honours.

// File: rtl/spi_stall_pkg.sv
// Shared types for the SPI stall slave: the decoded channel selection.
package spi_stall_pkg;
    typedef enum logic [1:0] {
        CH_NONE  = 2'd0,
        CH_DATA0 = 2'd1,
        CH_DATA1 = 2'd2,
        CH_CFG   = 2'd3
    } chan_e;
endpackage

// File: rtl/spi_sync.sv
// Two-flop synchronizer for a bundle of independent asynchronous inputs.
// Assumes each bit is slow against clk; bits are not kept coherent.
module spi_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_bit_engine.sv
// Serial shift engine. It detects SCK edges in the core clock, samples MOSI
// on the sampling edge and updates MISO on the other edge. Assumes that
// sck_s and mosi_s come through equal synchronizer delay, and that
// clk >= 4x SCK.
module spi_bit_engine #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          active,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [BW-1:0] tx_byte,
    output logic          miso_bit,
    output logic          byte_done,
    output logic [BW-1:0] rx_byte
);
    localparam int               CNTW = $clog2(BW);
    localparam logic [CNTW-1:0]  LAST = CNTW'(BW - 1);

    logic            sck_d, active_d;
    logic [CNTW-1:0] bit_cnt;
    logic [BW-1:0]   rx_sr, tx_sr;
    logic            sck_edge, sample_e, shift_e, start;

    // Previous SCK level and select state, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            active_d <= 1'b0;
        end else begin
            sck_d    <= sck_s;
            active_d <= active;
        end
    end

    assign sck_edge = sck_s ^ sck_d;
    assign sample_e = sck_edge && (sck_s == ~(cpol ^ cpha));
    assign shift_e  = sck_edge && (sck_s == (cpol ^ cpha));
    assign start    = active && !active_d;

    // Bit counting, receive shifting and transmit loading and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else if (!active) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (start)
                tx_sr <= tx_byte;
            if (sample_e) begin
                rx_sr <= {rx_sr[BW-2:0], mosi_s};
                if (bit_cnt == LAST) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sr[BW-2:0], mosi_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (shift_e) begin
                if (bit_cnt == '0)
                    tx_sr <= tx_byte;
                else
                    tx_sr <= {tx_sr[BW-2:0], 1'b0};
            end
        end
    end

    assign miso_bit = tx_sr[BW-1];

    // R2: a completed byte follows a sampling edge of the previous cycle.
    a_r2_done_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(sample_e));
endmodule

// File: rtl/rx_byte_fifo.sv
// Synchronous byte FIFO whose head byte is visible before it is popped.
// A push when full and a pop when empty are ignored.
module rx_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int             AW   = $clog2(DEPTH);
    localparam int             CW   = $clog2(DEPTH + 1);
    localparam logic [CW-1:0]  FULL = CW'(DEPTH);
    localparam logic [AW-1:0]  TOP  = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);

    // Storage write; no reset is needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == TOP) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == TOP) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assign dout = mem[rptr];

    // R7: a refused write leaves the occupancy unchanged.
    a_r7_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));
    // R11: a pop on an empty FIFO leaves it empty.
    a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '0) && pop && !push) |=> (count == '0));
endmodule

// File: rtl/spi_stall_slave.sv
// SPI slave top level. It decodes three selects into two data channels and
// one configuration channel, stores data bytes in per-channel FIFOs and
// raises stall when the addressed FIFO is nearly full. Assumes that clk
// runs at least 4x SCK and that mode inputs are static during a transfer.
module spi_stall_slave
    import spi_stall_pkg::*;
#(
    parameter int BW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic [2:0]    cs_n,
    input  logic          mosi,
    output logic          miso,
    output logic          miso_oe,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          single_mode,
    input  logic          rw_sel,
    input  logic [BW-1:0] tx_byte,
    output logic          stall,
    output logic [1:0]    mbox,
    output logic [1:0]    ovf,
    input  logic [1:0]    rd_pop,
    output logic [BW-1:0] rd_byte0,
    output logic [BW-1:0] rd_byte1,
    output logic          cfg_valid,
    output logic [BW-1:0] cfg_byte
);
    localparam int            NCH  = 2;
    localparam int            CW   = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] HIGH = CW'(DEPTH - 1);

    logic [4:0]    sync_q;
    logic [2:0]    cs_s;
    logic          sck_s, mosi_s;
    chan_e         chan;
    logic          active, store_ok, byte_done;
    logic [BW-1:0] rx_byte;
    logic [NCH-1:0] take, push, full;
    logic [CW-1:0]  cnt   [NCH];
    logic [BW-1:0]  head  [NCH];

    spi_sync #(.W(5), .RST_VAL(5'b11100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, mosi}), .q(sync_q)
    );
    assign cs_s   = sync_q[4:2];
    assign sck_s  = sync_q[1];
    assign mosi_s = sync_q[0];

    // Select decode with priority to the lowest index; single mode uses only select 0.
    always_comb begin
        chan = CH_NONE;
        if (!cs_s[0])                      chan = CH_DATA0;
        else if (!single_mode && !cs_s[1]) chan = CH_DATA1;
        else if (!single_mode && !cs_s[2]) chan = CH_CFG;
    end

    assign active   = (chan != CH_NONE);
    assign store_ok = !(single_mode && rw_sel);

    spi_bit_engine #(.BW(BW)) u_engine (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .mosi_s(mosi_s),
        .active(active), .cpol(cpol), .cpha(cpha), .tx_byte(tx_byte),
        .miso_bit(miso), .byte_done(byte_done), .rx_byte(rx_byte)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam chan_e MINE = (g == 0) ? CH_DATA0 : CH_DATA1;

        assign take[g] = byte_done && (chan == MINE) && store_ok;
        assign push[g] = take[g] && !full[g];
        assign mbox[g] = (cnt[g] != '0);

        rx_byte_fifo #(.W(BW), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(push[g]), .din(rx_byte),
            .pop(rd_pop[g]), .dout(head[g]), .count(cnt[g]), .full(full[g])
        );

        // Sticky overflow when a byte arrives for a full FIFO.
        always_ff @(posedge clk) begin
            if (!rst_n)                   ovf[g] <= 1'b0;
            else if (take[g] && full[g])  ovf[g] <= 1'b1;
        end

        // R7: the overflow flag never clears outside reset.
        a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[g] |=> ovf[g]);
    end

    assign rd_byte0 = head[0];
    assign rd_byte1 = head[1];

    assign stall = ((chan == CH_DATA0) && (cnt[0] >= HIGH)) ||
                   ((chan == CH_DATA1) && (cnt[1] >= HIGH));

    assign miso_oe   = active && !(single_mode && !rw_sel);
    assign cfg_valid = byte_done && (chan == CH_CFG);
    assign cfg_byte  = rx_byte;

    // R5: stall only while a data channel is selected.
    a_r5_stall_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (chan == CH_DATA0 || chan == CH_DATA1));
    // R4: a configuration byte never writes a data FIFO.
    a_r4_cfg_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (push == '0));
endmodule

// File: tb/spi_stall_slave_test.sv
module spi_stall_slave_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic [2:0] cs_n = 3'b111;
    logic       mosi = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0, single_mode = 1'b0, rw_sel = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [1:0] rd_pop = 2'b00;
    logic       miso, miso_oe, stall, cfg_valid;
    logic [1:0] mbox, ovf;
    logic [7:0] rd_byte0, rd_byte1, cfg_byte;

    int checks = 0, fails = 0;
    int cfg_cnt = 0;
    logic [7:0] cfg_last = 8'h00;
    logic done = 1'b0;

    always #2 clk = ~clk;

    spi_stall_slave uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .cpol(cpol), .cpha(cpha),
        .single_mode(single_mode), .rw_sel(rw_sel), .tx_byte(tx_byte),
        .stall(stall), .mbox(mbox), .ovf(ovf), .rd_pop(rd_pop),
        .rd_byte0(rd_byte0), .rd_byte1(rd_byte1),
        .cfg_valid(cfg_valid), .cfg_byte(cfg_byte)
    );

    // Record configuration strobes.
    always @(negedge clk) begin
        if (cfg_valid) begin
            cfg_cnt  <= cfg_cnt + 1;
            cfg_last <= cfg_byte;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        cpol = m[1];
        cpha = m[0];
        sck  = m[1];
        step(6);
    endtask

    task automatic sel(input int ch);
        cs_n = 3'b111;
        cs_n[ch] = 1'b0;
    endtask

    task automatic desel();
        step(HALF);
        cs_n = 3'b111;
        step(12);
    endtask

    // Shift n bits of b out, most significant first; return what came back on MISO.
    task automatic xfer_bits(input int n, input logic [7:0] b, output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            if (!cpha) begin
                mosi = b[i];
                step(HALF);
                sck = ~sck;
                got[i] = miso;
                step(HALF);
                sck = ~sck;
            end else begin
                step(HALF);
                sck = ~sck;
                mosi = b[i];
                step(HALF);
                sck = ~sck;
                got[i] = miso;
            end
        end
        step(HALF);
    endtask

    task automatic pop(input int ch);
        rd_pop[ch] = 1'b1;
        step(1);
        rd_pop = 2'b00;
        step(1);
    endtask

    // Vectors: {mode[1:0], channel[1:0], tx_byte, mosi byte}
    localparam logic [19:0] VEC [8] = '{
        {2'd0, 2'd0, 8'hA5, 8'h3C},
        {2'd1, 2'd1, 8'h5A, 8'hC3},
        {2'd2, 2'd0, 8'h81, 8'h7E},
        {2'd3, 2'd1, 8'hFF, 8'h01},
        {2'd0, 2'd2, 8'h00, 8'h96},
        {2'd3, 2'd2, 8'h12, 8'h80},
        {2'd1, 2'd0, 8'h0F, 8'hF0},
        {2'd2, 2'd1, 8'hC8, 8'h2D}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        int c0;
        step(4);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        chk("R1 stall", stall, 0);
        chk("R1 mbox", mbox, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 miso_oe", miso_oe, 0);
        chk("R1 cfg_valid", cfg_valid, 0);

        // Table walk: R2, R3, R4, R6 across all four modes
        for (int v = 0; v < 8; v++) begin
            logic [1:0] m, ch;
            logic [7:0] tb, rb;
            {m, ch, tb, rb} = VEC[v];
            set_mode(m);
            tx_byte = tb;
            c0 = cfg_cnt;
            sel(int'(ch));
            xfer_bits(8, rb, got);
            desel();
            chk("R3 miso byte", got, tb);
            if (ch == 2'd2) begin
                chk("R4 cfg strobe count", cfg_cnt - c0, 1);
                chk("R4 cfg byte", cfg_last, rb);
                chk("R4 no fifo write", mbox, 0);
            end else begin
                chk("R6 mbox set", mbox, (ch == 2'd0) ? 2'b01 : 2'b10);
                chk("R2 received byte", (ch == 2'd0) ? rd_byte0 : rd_byte1, rb);
                pop(int'(ch));
                chk("R6 mbox clear", mbox, 0);
            end
        end

        // R5, R7, R11: fill FIFO 0 in mode 0 and overflow it
        set_mode(2'd0);
        sel(0);
        step(4);
        chk("R9 oe when selected", miso_oe, 1);
        for (int k = 0; k < 9; k++) begin
            xfer_bits(8, (k == 8) ? 8'hEE : 8'(k * 17 + 1), got);
            if (k == 5) chk("R5 stall low at 6 used", stall, 0);
            if (k == 6) chk("R5 stall high at 7 used", stall, 1);
            if (k == 7) chk("R7 no ovf when just full", ovf, 0);
        end
        chk("R7 ovf set", ovf, 2'b01);
        chk("R5 stall while full", stall, 1);
        desel();
        chk("R5 stall low when idle", stall, 0);
        chk("R9 oe low when idle", miso_oe, 0);
        for (int k = 0; k < 8; k++) begin
            chk("R11 fifo order", rd_byte0, 8'(k * 17 + 1));
            pop(0);
        end
        chk("R7 dropped byte absent", mbox, 0);
        pop(0);
        chk("R11 empty pop ignored", mbox, 0);
        chk("R7 ovf sticky", ovf, 2'b01);

        // R5: the configuration channel never stalls
        sel(2);
        step(6);
        chk("R5 no stall on cfg", stall, 0);
        desel();

        // R8: partial byte dropped
        set_mode(2'd3);
        sel(1);
        xfer_bits(4, 8'hF0, got);
        desel();
        chk("R8 partial not stored", mbox, 0);
        sel(1);
        xfer_bits(8, 8'h6B, got);
        desel();
        chk("R8 next byte aligned", rd_byte1, 8'h6B);
        pop(1);
        chk("R8 one entry only", mbox, 0);

        // R4 priority: cs0 and cs1 both low
        set_mode(2'd0);
        cs_n = 3'b100;
        xfer_bits(8, 8'h44, got);
        desel();
        chk("R4 priority to cs0", mbox, 2'b01);
        pop(0);

        // R10 / R9: single-channel mode
        single_mode = 1'b1;
        rw_sel = 1'b1;
        tx_byte = 8'hB7;
        sel(0);
        step(4);
        chk("R9 oe in single read", miso_oe, 1);
        xfer_bits(8, 8'h39, got);
        desel();
        chk("R10 single read returns tx", got, 8'hB7);
        chk("R10 single read stores nothing", mbox, 0);
        rw_sel = 1'b0;
        sel(0);
        step(4);
        chk("R9 oe low in single write", miso_oe, 0);
        xfer_bits(8, 8'h5C, got);
        desel();
        chk("R10 single write stored", rd_byte0, 8'h5C);
        pop(0);
        c0 = cfg_cnt;
        sel(1);
        step(4);
        chk("R10 cs1 ignored oe", miso_oe, 0);
        xfer_bits(8, 8'h77, got);
        desel();
        sel(2);
        xfer_bits(8, 8'h78, got);
        desel();
        chk("R10 cs1 cs2 ignored", mbox, 0);
        chk("R10 cs2 no cfg strobe", cfg_cnt - c0, 0);
        single_mode = 1'b0;
        rw_sel = 1'b1;
        sel(1);
        xfer_bits(8, 8'hD2, got);
        desel();
        chk("R10 rw_sel ignored in dual", rd_byte1, 8'hD2);
        chk("R6 mbox1", mbox, 2'b10);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule